// File: doc/BRIEF.md
# Tick Counter with Compare Interrupt

This block is a free-running tick counter with one compare register. Each cycle on which the rate-enable input is high, the counter advances by one. When the count reaches an armed compare value, the block raises a one-cycle software-interrupt set pulse and a wake pulse for a halted core. The top bit of the count register is a trap flag for non-privileged reads. The top bit of the compare register is an interrupt-disable flag. Neither top bit is part of the 63-bit value.

A core holds three copies of the block: tick, system tick and hypervisor system tick. All three are fed the same nominal 100 MHz rate enable. The `SRC_KIND` parameter selects which software-interrupt bit a copy drives. Value 0 drives the tick-match bit. Any other value drives the system-tick-match bit.

Top module: `tick_cmp_timer`

## Requirements
- R1: A count write loads `cnt_wdata[62:0]` as the count and `cnt_wdata[63]` into the trap flag. In a cycle with both a write and a tick, the write wins.
- R2: `cnt_rdata[62:0]` is the current count. `cnt_rdata[63]` is 1 exactly when the trap flag is set.
- R3: The count increases by one at each clock edge where `tick_en` is high, and it wraps from all-ones (63 bits) to zero.
- R4: A limit write loads `lim_wdata[62:0]` as the compare value and `lim_wdata[63]` into the disable flag (1 = interrupt disabled).
- R5: A limit write arms a match only if its compare value is non-zero and its disable bit is 0. Any other limit write cancels a match that is already armed, so no pulse follows.
- R6: An armed match fires at a tick edge where the count equals the compare value. In the next cycle, `softint_set` holds a single bit for one cycle and `wake` is high for that same cycle. The bit is bit 0 when `SRC_KIND` is 0 and bit 1 otherwise. The match then disarms, so it fires only once.
- R7: If the count is already past the compare value one cycle after the limit write, the match fires at the next tick edge instead of being lost.
- R8: After reset the count is 0 and the trap flag is set, so a read returns 0x8000_0000_0000_0000. The disable flag is also set, and no match is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Rate enable, one count per high cycle |
| cnt_wr | input | 1 | Count write strobe |
| cnt_wdata | input | 64 | Count write data, bit 63 = trap flag |
| cnt_rdata | output | 64 | Count read data, bit 63 = trap flag |
| lim_wr | input | 1 | Limit write strobe |
| lim_wdata | input | 64 | Limit write data, bit 63 = disable flag |
| softint_set | output | 2 | One-cycle set pulse for the match softint bits |
| wake | output | 1 | One-cycle wake pulse for a halted core |

## Verification
A count write shows on `cnt_rdata` one cycle after its strobe, and each tick shows one cycle after its edge. The bench samples both at the falling edge that follows. For a match, the driver knows which tick edge should fire it and pushes the cycle number of that edge, plus one register stage, into a queue. The monitor pops the entry when a pulse appears and compares the cycle and the bits, so a pulse that is early, late, extra or missing is reported. Each limit write is followed by one idle cycle, which lets the past-due check settle before the next tick.

// File: rtl/tick_cmp_timer.sv
module tick_cmp_timer #(
  parameter int CNT_W    = 64,
  parameter int SRC_KIND = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  output logic [CNT_W-1:0] cnt_rdata,
  input  logic             lim_wr,
  input  logic [CNT_W-1:0] lim_wdata,
  output logic [1:0]       softint_set,
  output logic             wake
);
  localparam int VW = CNT_W - 1;
  localparam logic [1:0] SET_BIT = (SRC_KIND == 0) ? 2'b01 : 2'b10;

  logic [VW-1:0] count, cmp;
  logic          npt, dis, armed, chk, overdue;
  logic          new_arm, fire;

  assign cnt_rdata = {npt, count};
  assign new_arm   = (lim_wdata[VW-1:0] != '0) && !lim_wdata[VW];
  assign fire      = armed && tick_en && !lim_wr && ((count == cmp) || overdue);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      npt   <= 1'b1;
    end else if (cnt_wr) begin
      count <= cnt_wdata[VW-1:0];
      npt   <= cnt_wdata[VW];
    end else if (tick_en) begin
      count <= count + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp     <= '0;
      dis     <= 1'b1;
      armed   <= 1'b0;
      chk     <= 1'b0;
      overdue <= 1'b0;
    end else begin
      chk <= lim_wr;
      if (lim_wr) begin
        cmp     <= lim_wdata[VW-1:0];
        dis     <= lim_wdata[VW];
        armed   <= new_arm;
        overdue <= 1'b0;
      end else if (fire) begin
        armed   <= 1'b0;
        overdue <= 1'b0;
      end else if (chk && armed && (count > cmp)) begin
        overdue <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      softint_set <= 2'b00;
      wake        <= 1'b0;
    end else begin
      softint_set <= fire ? SET_BIT : 2'b00;
      wake        <= fire;
    end
  end

  p_cnt_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> cnt_rdata == $past(cnt_wdata));

  p_tick_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !cnt_wr) |=> count == $past(count) + 1'b1);

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !cnt_wr) |=> $stable(cnt_rdata));

  p_no_arm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_wr && !new_arm) |=> !armed);

  p_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(softint_set));

  p_wake_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (softint_set != 2'b00) == wake);

  p_one_shot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> !armed);

  p_dis_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dis |=> softint_set == 2'b00);
endmodule

// File: tb/tick_cmp_timer_test.sv
module tick_cmp_timer_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        cnt_wr = 1'b0;
  logic [63:0] cnt_wdata = '0;
  logic [63:0] cnt_rdata, cnt_rdata_s;
  logic        lim_wr = 1'b0;
  logic [63:0] lim_wdata = '0;
  logic [1:0]  softint_set, softint_set_s;
  logic        wake, wake_s;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  int exp_cyc[$];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tick_cmp_timer #(.CNT_W(64), .SRC_KIND(0)) uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt_wr(cnt_wr),
    .cnt_wdata(cnt_wdata), .cnt_rdata(cnt_rdata), .lim_wr(lim_wr),
    .lim_wdata(lim_wdata), .softint_set(softint_set), .wake(wake));

  tick_cmp_timer #(.CNT_W(64), .SRC_KIND(1)) uut_sys (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt_wr(cnt_wr),
    .cnt_wdata(cnt_wdata), .cnt_rdata(cnt_rdata_s), .lim_wr(lim_wr),
    .lim_wdata(lim_wdata), .softint_set(softint_set_s), .wake(wake_s));

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (exp_cyc.size() > 0 && exp_cyc[0] < cyc) begin
        n_run++; n_fail++;
        $display("FAIL R6: pulse missing, got none expected at cycle %0d", exp_cyc[0]);
        void'(exp_cyc.pop_front());
      end
      if (wake || softint_set != 2'b00 || wake_s || softint_set_s != 2'b00) begin
        if (exp_cyc.size() == 0) begin
          n_run++; n_fail++;
          $display("FAIL R5: unexpected pulse at cycle %0d got %b expected 00", cyc, softint_set);
        end else begin
          check("R6 cycle", 64'(cyc), 64'(exp_cyc.pop_front()));
          check("R6 tick bit", {62'd0, softint_set}, 64'd1);
          check("R6 wake", {63'd0, wake}, 64'd1);
          check("R6 system bit", {62'd0, softint_set_s}, 64'd2);
          check("R6 system wake", {63'd0, wake_s}, 64'd1);
        end
      end
    end
  end

  task automatic wr_cnt(input logic [63:0] d, input logic with_tick);
    @(negedge clk);
    cnt_wr = 1'b1; cnt_wdata = d; tick_en = with_tick;
    @(negedge clk);
    cnt_wr = 1'b0; tick_en = 1'b0;
  endtask

  task automatic wr_lim(input logic [63:0] d);
    @(negedge clk);
    lim_wr = 1'b1; lim_wdata = d;
    @(negedge clk);
    lim_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_ticks(input int n, input int fire_at);
    @(negedge clk);
    tick_en = 1'b1;
    if (fire_at > 0) exp_cyc.push_back(cyc + fire_at);
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 reset read", cnt_rdata, 64'h8000_0000_0000_0000);
    check("R8 reset softint", {62'd0, softint_set}, 64'd0);
    do_ticks(4, 0);
    check("R8 reset disabled, R3 count", cnt_rdata, 64'h8000_0000_0000_0004);

    wr_cnt(64'd5, 1'b0);
    check("R1 load, R2 flag clear", cnt_rdata, 64'd5);
    wr_cnt(64'h8000_0000_0000_0007, 1'b0);
    check("R2 flag forced", cnt_rdata, 64'h8000_0000_0000_0007);
    wr_cnt(64'd20, 1'b1);
    check("R1 write beats tick", cnt_rdata, 64'd20);
    do_ticks(3, 0);
    check("R3 three ticks", cnt_rdata, 64'd23);
    wr_cnt(64'h7FFF_FFFF_FFFF_FFFF, 1'b0);
    do_ticks(1, 0);
    check("R3 wrap", cnt_rdata, 64'd0);

    wr_cnt(64'd100, 1'b0);
    wr_lim(64'd103);
    do_ticks(12, 4);
    check("R6 count after match", cnt_rdata, 64'd112);

    wr_cnt(64'd200, 1'b0);
    wr_lim(64'h8000_0000_0000_00CD);
    do_ticks(10, 0);
    check("R4 disabled limit count", cnt_rdata, 64'd210);
    wr_lim(64'd205);
    do_ticks(3, 1);
    check("R7 past-due count", cnt_rdata, 64'd213);

    wr_cnt(64'h7FFF_FFFF_FFFF_FFFE, 1'b0);
    wr_lim(64'd0);
    do_ticks(4, 0);
    check("R5 zero limit count", cnt_rdata, 64'd2);

    wr_cnt(64'd290, 1'b0);
    wr_lim(64'd300);
    wr_lim(64'd0);
    do_ticks(20, 0);
    wr_cnt(64'd400, 1'b0);
    wr_lim(64'd405);
    wr_lim(64'h8000_0000_0000_0195);
    do_ticks(10, 0);
    check("R5 cancel count", cnt_rdata, 64'd410);

    wr_lim(64'd415);
    do_ticks(8, 6);
    repeat (3) @(negedge clk);
    check("R6 queue drained", 64'(exp_cyc.size()), 64'd0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule